// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error-Flag Status

This block takes a serial line running at a fixed rate and rebuilds each character from it. A character is one low start bit, eight data bits sent least significant bit first, an optional parity bit, and one stop bit. An external pulse at sixteen times the bit rate sets the timing. Each finished character goes to a receive data register. A four-flag status word reports data-full, overrun, framing and parity conditions to software.

The block decides per character whether the byte is kept or discarded. An overrun always discards the new byte. A framing or parity problem on its own still delivers the byte. While any of the three error flags is set, the receiver stays idle and ignores the line. It starts again once software has cleared those flags. A read strobe on the data register clears the data-full flag. Software clears a flag by writing a zero to its bit position. Two interrupt outputs report data ready and error conditions, each gated by its own enable.

Top module: `uart_rx_flags`

## Requirements
- R1: A character with a good stop bit and, when parity is enabled, correct parity loads its byte into `rx_data`, LSB first. It sets the data-full flag at `st_flags[0]`, provided that flag was 0 when the character completed.
- R2: With `par_en`=1, a parity bit follows the data bits. `par_odd`=0 expects an even count of ones across the data and parity bits; `par_odd`=1 expects an odd count. A mismatch sets the parity flag at `st_flags[3]`.
- R3: A stop bit sampled as 0 sets the framing flag at `st_flags[2]`.
- R4: A framing error, a parity error, or both, with no overrun, still loads the byte into `rx_data`. The data-full flag keeps its previous value.
- R5: A character that completes while data-full is 1 sets the overrun flag at `st_flags[1]`, discards its byte and leaves data-full at 1. Framing and parity flags are also set independently for that same character when their conditions hold.
- R6: While any of `st_flags[3:1]` is 1, the receiver accepts no new character: `rx_data` and the flags do not change in response to line activity.
- R7: A one-cycle `rd_stb` pulse clears data-full, also when the overrun flag is set.
- R8: A `st_wr` pulse clears each flag whose bit in `st_wdata` is 0 and which is currently 1. Writing a 1 to a bit has no effect. Bit positions: 0 data-full, 1 overrun, 2 framing, 3 parity.
- R9: The receiver recognises a start bit on a high-to-low transition of the line and confirms it on the 8th oversample tick. If the line is high at that tick, the receiver returns to idle and records nothing.
- R10: `irq_rx` equals data-full AND `rx_ie`. `irq_err` equals (overrun OR framing OR parity) AND `err_ie`.
- R11: After reset, all flags are 0, `rx_data` is 0 and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idles high |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rd_stb | input | 1 | Read of the data register |
| st_wr | input | 1 | Write strobe to the status flags |
| st_wdata | input | 4 | Write data; a 0 bit clears that flag |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| rx_data | output | 8 | Receive data register |
| st_flags | output | 4 | Flags: [0] full, [1] overrun, [2] framing, [3] parity |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The assertions check four things on every cycle:
- the data register changes only on a completed character that arrives while data-full is clear;
- overrun rises only while data-full was already set;
- data-full rises only on an error-free character;
- the frame sequencer stays idle while stalled.

Only the bench scenarios can show the rest: the parity polarity, least-significant-bit-first bit order, rejection of a false start, the full set of error combinations, and that clearing the error flags resumes reception.

// File: rtl/uart_rx_flags_pkg.sv
package uart_rx_flags_pkg;
  localparam int FLG_FULL = 0;
  localparam int FLG_OVR  = 1;
  localparam int FLG_FRM  = 2;
  localparam int FLG_PAR  = 3;
  localparam int FLG_N    = 4;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_START = 3'd1,
    SEQ_DATA  = 3'd2,
    SEQ_PAR   = 3'd3,
    SEQ_STOP  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign pipe_d[g] = d_i;
      end else begin : g_rest
        assign pipe_d[g] = pipe_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_seq.sv
module uart_rx_seq
  import uart_rx_flags_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              hold_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frm_err_o,
  output logic              par_err_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  seq_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic              prev_q, prev_d;
  logic              perr_q, perr_d;
  logic              ferr_q, ferr_d;
  logic              done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    shf_d   = shf_q;
    prev_d  = prev_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    done_d  = 1'b0;
    if (tick_i) begin
      prev_d = line_i;
      unique case (state_q)
        SEQ_IDLE: begin
          if (!hold_i && prev_q && !line_i) begin
            state_d = SEQ_START;
            cnt_d   = '0;
          end
        end
        SEQ_START: begin
          if (cnt_q == MID_CNT) begin
            cnt_d  = '0;
            bit_d  = '0;
            perr_d = 1'b0;
            state_d = line_i ? SEQ_IDLE : SEQ_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SEQ_DATA: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d = '0;
            shf_d = {line_i, shf_q[DATA_W-1:1]};
            if (bit_q == LAST_BIT) state_d = par_en_i ? SEQ_PAR : SEQ_STOP;
            else                   bit_d   = bit_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SEQ_PAR: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d   = '0;
            perr_d  = line_i ^ (^shf_q) ^ par_odd_i;
            state_d = SEQ_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SEQ_STOP: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d   = '0;
            ferr_d  = !line_i;
            done_d  = 1'b1;
            state_d = SEQ_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shf_q   <= '0;
      prev_q  <= 1'b1;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shf_q   <= shf_d;
      prev_q  <= prev_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      done_q  <= done_d;
    end
  end

  assign done_o    = done_q;
  assign data_o    = shf_q;
  assign frm_err_o = ferr_q;
  assign par_err_o = perr_q;

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE && hold_i) |=> (state_q == SEQ_IDLE));

  // R9
  start_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_START && state_d == SEQ_DATA) |-> (cnt_q == MID_CNT && !line_i));

  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
  import uart_rx_flags_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              frm_err_i,
  input  logic              par_err_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [FLG_N-1:0]  wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [FLG_N-1:0]  flags_o,
  output logic              hold_o
);
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [FLG_N-1:0]  flg_q, flg_d;
  logic [FLG_N-1:0]  clr_req;
  logic              ovr_now;

  always_comb begin
    clr_req = {FLG_N{wr_i}} & ~wdata_i & flg_q;
    flg_d   = flg_q & ~clr_req;
    if (rd_i) flg_d[FLG_FULL] = 1'b0;
    rdata_d = rdata_q;
    ovr_now = done_i && flg_q[FLG_FULL];
    if (done_i) begin
      if (ovr_now) begin
        flg_d[FLG_OVR]  = 1'b1;
        flg_d[FLG_FULL] = 1'b1;
      end else begin
        rdata_d = data_i;
        if (!frm_err_i && !par_err_i) flg_d[FLG_FULL] = 1'b1;
      end
      if (frm_err_i) flg_d[FLG_FRM] = 1'b1;
      if (par_err_i) flg_d[FLG_PAR] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      flg_q   <= '0;
    end else begin
      rdata_q <= rdata_d;
      flg_q   <= flg_d;
    end
  end

  assign rdata_o = rdata_q;
  assign flags_o = flg_q;
  assign hold_o  = flg_q[FLG_OVR] | flg_q[FLG_FRM] | flg_q[FLG_PAR];

  // R5
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[FLG_OVR]) |-> $past(flg_q[FLG_FULL]));

  // R4
  rdata_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_q != $past(rdata_q)) |-> $past(done_i && !flg_q[FLG_FULL]));

  // R1
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[FLG_FULL]) |-> $past(done_i && !frm_err_i && !par_err_i));

  // R7
  full_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flg_q[FLG_FULL]) |-> $past(rd_i || wr_i));
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_flags_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_stb,
  input  logic              st_wr,
  input  logic [3:0]        st_wdata,
  input  logic              rx_ie,
  input  logic              err_ie,
  output logic [DATA_W-1:0] rx_data,
  output logic [3:0]        st_flags,
  output logic              irq_rx,
  output logic              irq_err
);
  logic              line_s;
  logic              hold;
  logic              fr_done;
  logic [DATA_W-1:0] fr_data;
  logic              fr_ferr;
  logic              fr_perr;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rxd), .q_o(line_s)
  );

  uart_rx_seq #(.DATA_W(DATA_W), .OSR(OSR)) i_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(os_tick), .line_i(line_s),
    .par_en_i(par_en), .par_odd_i(par_odd), .hold_i(hold),
    .done_o(fr_done), .data_o(fr_data), .frm_err_o(fr_ferr), .par_err_o(fr_perr)
  );

  uart_rx_stat #(.DATA_W(DATA_W)) i_stat (
    .clk(clk), .rst_n(rst_n), .done_i(fr_done), .data_i(fr_data),
    .frm_err_i(fr_ferr), .par_err_i(fr_perr), .rd_i(rd_stb),
    .wr_i(st_wr), .wdata_i(st_wdata), .rdata_o(rx_data),
    .flags_o(st_flags), .hold_o(hold)
  );

  assign irq_rx  = st_flags[FLG_FULL] & rx_ie;
  assign irq_err = (st_flags[FLG_OVR] | st_flags[FLG_FRM] | st_flags[FLG_PAR]) & err_ie;

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (st_flags == '0 && !irq_rx && !irq_err));
endmodule

// File: tb/test_uart_rx_flags.sv
module test_uart_rx_flags;
  localparam int BIT_CLK = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rd_stb = 1'b0;
  logic       st_wr = 1'b0;
  logic [3:0] st_wdata = 4'hF;
  logic       rx_ie = 1'b1;
  logic       err_ie = 1'b1;
  logic [7:0] rx_data;
  logic [3:0] st_flags;
  logic       irq_rx;
  logic       irq_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uart_rx_flags i_uart_rx_flags (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd), .rd_stb(rd_stb), .st_wr(st_wr),
    .st_wdata(st_wdata), .rx_ie(rx_ie), .err_ie(err_ie), .rx_data(rx_data),
    .st_flags(st_flags), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      os_tick = (n % 4 == 0);
      n++;
    end
  end

  // {data, {par_en, par_odd, flip_parity, stop_value}, expected flags, expected data}
  localparam int NVEC = 6;
  localparam logic [23:0] VEC [NVEC] = '{
    {8'hA5, 4'b0001, 4'b0001, 8'hA5},
    {8'h3C, 4'b1001, 4'b0001, 8'h3C},
    {8'h81, 4'b1101, 4'b0001, 8'h81},
    {8'h5A, 4'b1011, 4'b1000, 8'h5A},
    {8'h0F, 4'b0000, 4'b0100, 8'h0F},
    {8'hF0, 4'b1010, 4'b1100, 8'hF0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic pe, input logic po,
                      input logic flip, input logic stopv);
    par_en  = pe;
    par_odd = po;
    hold_line(1'b0, BIT_CLK);
    for (int i = 0; i < 8; i++) hold_line(d[i], BIT_CLK);
    if (pe) hold_line((^d) ^ po ^ flip, BIT_CLK);
    hold_line(stopv, BIT_CLK);
    hold_line(1'b1, 2 * BIT_CLK);
  endtask

  task automatic rd_pulse();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_pulse(input logic [3:0] w);
    st_wdata = w;
    st_wr = 1'b1;
    @(negedge clk);
    st_wr = 1'b0;
    st_wdata = 4'hF;
    @(negedge clk);
  endtask

  task automatic clear_all();
    wr_pulse(4'b0000);
    rd_pulse();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 flags", 16'(st_flags), 16'h0);
    check("R11 data", 16'(rx_data), 16'h0);
    check("R11 irqs", 16'({irq_rx, irq_err}), 16'h0);
    rst_n = 1'b1;
    hold_line(1'b1, 2 * BIT_CLK);

    // table: R1 R2 R3 R4 R10
    for (int v = 0; v < NVEC; v++) begin
      clear_all();
      send(VEC[v][23:16], VEC[v][15], VEC[v][14], VEC[v][13], VEC[v][12]);
      check("R1/R2/R3 flags", 16'(st_flags), 16'(VEC[v][11:8]));
      check("R1/R4 data", 16'(rx_data), 16'(VEC[v][7:0]));
      check("R10 irqs", 16'({irq_rx, irq_err}),
            16'({VEC[v][8], |VEC[v][11:9]}));
    end

    // R5 overrun discards the new byte
    clear_all();
    send(8'h11, 1'b0, 1'b0, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R5 flags", 16'(st_flags), 16'b0011);
    check("R5 data", 16'(rx_data), 16'h11);
    // R6 stalled while overrun flag set
    send(8'h33, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R6 flags", 16'(st_flags), 16'b0011);
    check("R6 data", 16'(rx_data), 16'h11);
    // R7 read after overrun clears full
    rd_pulse();
    check("R7 flags", 16'(st_flags), 16'b0010);
    send(8'h44, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R6 stall data", 16'(rx_data), 16'h11);
    check("R6 stall flags", 16'(st_flags), 16'b0010);
    // R8 write zero at bit 1 clears overrun, reception resumes
    wr_pulse(4'b1101);
    check("R8 clear ovr", 16'(st_flags), 16'b0000);
    send(8'h55, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R6 resume", 16'({st_flags, rx_data}), 16'({4'b0001, 8'h55}));
    // R8 writing ones has no effect
    wr_pulse(4'b1111);
    check("R8 ones", 16'(st_flags), 16'b0001);

    // R5 overrun with framing and parity errors together
    send(8'h88, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R5 all flags", 16'(st_flags), 16'b1111);
    check("R5 all data", 16'(rx_data), 16'h55);

    // R9 false start rejected
    clear_all();
    hold_line(1'b0, 8);
    hold_line(1'b1, 4 * BIT_CLK);
    check("R9 glitch", 16'({st_flags, rx_data}), 16'({4'b0000, 8'h55}));
    send(8'h99, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 after glitch", 16'({st_flags, rx_data}), 16'({4'b0001, 8'h99}));

    // R10 enables gate the interrupt outputs
    rx_ie = 1'b0;
    @(negedge clk);
    check("R10 rx gated", 16'(irq_rx), 16'h0);
    send(8'hAA, 1'b0, 1'b0, 1'b0, 1'b1);
    err_ie = 1'b0;
    @(negedge clk);
    check("R10 err gated", 16'({st_flags, irq_err}), 16'({4'b0011, 1'b0}));
    err_ie = 1'b1;
    rx_ie = 1'b1;
    @(negedge clk);
    check("R10 both on", 16'({irq_rx, irq_err}), 16'b11);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule